// File: doc/BRIEF.md
# Spin-Loop Exit Arbiter

This block decides, for every PAUSE event that a core reports, whether the event completes normally or forces an exit to the hypervisor. It weighs the current privilege level against two control bits: an unconditional-exit control and a loop-detection control. At privilege level 0, with only loop detection enabled, it tells a tight spin loop apart from isolated PAUSEs. It does this by timing each PAUSE against two thresholds. One limits the spacing between consecutive PAUSEs. The other limits how long a loop may run before it is cut short.

The core drives `pause_valid` for one cycle together with the privilege level and the controls as they stand at that moment. The block also watches a free-running time counter that advances at timestamp rate, and a pulse that marks each VM entry. One cycle later it returns a single-cycle decision carrying a two-bit reason code. Internally it keeps the time of the last loop-evaluated PAUSE, the time at which the current loop began, and a flag that says whether that history is usable.

Top module: `pause_loop_gate`

## Requirements
- R1: At a nonzero privilege level the loop-detection control has no effect. The PAUSE exits with reason 2'b01 when the unconditional-exit control is 1, and completes with reason 2'b00 otherwise.
- R2: At privilege level 0 with the unconditional-exit control at 1, the PAUSE exits with reason 2'b01, whatever the loop-detection control holds.
- R3: At privilege level 0 with both controls at 0, the PAUSE completes with reason 2'b00.
- R4: At privilege level 0 with only loop detection enabled, a PAUSE opens a new loop when the time since the previous loop-evaluated PAUSE is strictly greater than the gap threshold. A PAUSE that opens a loop completes with reason 2'b00. An elapsed time equal to the threshold does not open a loop.
- R5: The first loop-evaluated PAUSE after reset, or after a VM-entry pulse, always opens a loop. A VM entry in the same cycle as the PAUSE counts as coming before it.
- R6: A loop-evaluated PAUSE that does not open a loop exits with reason 2'b10 when the time since the loop opened is strictly greater than the window threshold. Otherwise it completes with reason 2'b00.
- R7: Elapsed times are unsigned differences modulo 2^TS_W, so the results stay correct when the time counter wraps around.
- R8: Only loop-evaluated PAUSEs change the stored history. Each one records its time as the previous-PAUSE time. One that opens a loop also records its time as the loop start. PAUSEs handled under R1, R2 or R3 leave the history untouched.
- R9: `decision_valid` is high for exactly the one cycle after each `pause_valid` cycle. `exit_req` is high exactly when the reason is nonzero. With no decision, reason and `exit_req` are 0.
- R10: Synchronous active-high reset clears the outputs, both stored times and the history-valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_valid | input | 1 | One-cycle PAUSE event from the core |
| cpl | input | CPL_W (2) | Current privilege level |
| ctl_pause_exit | input | 1 | Unconditional PAUSE-exit control |
| ctl_loop_exit | input | 1 | Spin-loop detection control |
| gap_limit | input | TS_W (32) | Largest spacing that keeps PAUSEs in one loop |
| window_limit | input | TS_W (32) | Largest loop duration that still completes normally |
| tsc_now | input | TS_W (32) | Free-running time counter |
| vm_entry | input | 1 | One-cycle pulse on VM entry |
| decision_valid | output | 1 | Decision pulse, one cycle after `pause_valid` |
| exit_req | output | 1 | The PAUSE must exit |
| exit_reason | output | 2 | 00 normal, 01 unconditional exit, 10 spin-loop exit |

## Verification
The bench goes after the exact threshold edges. A spacing equal to the gap, or a loop age equal to the window, must not count; a design that compared with greater-or-equal would split loops early or exit one tick too soon. It interleaves PAUSEs at nonzero privilege and forced exits within running loops. A design that let those update the history would move the loop start and change later verdicts. It also places runs across counter wraparound and VM entries, which expose signed or unmasked subtraction and a history flag that survives VM entry.

// File: rtl/plg_pkg.sv
package plg_pkg;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_FORCE = 2'b01,
    RSN_LOOP  = 2'b10
  } plg_reason_e;

  typedef enum logic [1:0] {
    PATH_NORMAL = 2'b00,
    PATH_FORCED = 2'b01,
    PATH_LOOP   = 2'b10
  } plg_path_e;

endpackage

// File: rtl/plg_route.sv
module plg_route #(
  parameter int CPL_W = 2
) (
  input  logic [CPL_W-1:0] cpl,
  input  logic             ctl_pause_exit,
  input  logic             ctl_loop_exit,
  output plg_pkg::plg_path_e path
);
  import plg_pkg::*;

  logic privileged;
  assign privileged = (cpl == '0);

  // Unconditional exit wins; loop detection only counts at level 0.
  always_comb begin
    if (ctl_pause_exit)                  path = PATH_FORCED;
    else if (privileged && ctl_loop_exit) path = PATH_LOOP;
    else                                 path = PATH_NORMAL;
  end
endmodule

// File: rtl/plg_judge.sv
module plg_judge #(
  parameter int TS_W = 32
) (
  input  logic [TS_W-1:0] now,
  input  logic [TS_W-1:0] prev_ts,
  input  logic [TS_W-1:0] start_ts,
  input  logic            hist_ok,
  input  logic [TS_W-1:0] gap_limit,
  input  logic [TS_W-1:0] window_limit,
  output logic            opens_loop,
  output logic            window_hit
);

  function automatic logic [TS_W-1:0] elapsed(input logic [TS_W-1:0] later,
                                               input logic [TS_W-1:0] earlier);
    return later - earlier;
  endfunction

  function automatic logic beyond(input logic [TS_W-1:0] span,
                                  input logic [TS_W-1:0] limit);
    return span > limit;
  endfunction

  logic [TS_W-1:0] since_prev;
  logic [TS_W-1:0] since_start;

  assign since_prev  = elapsed(now, prev_ts);
  assign since_start = elapsed(now, start_ts);
  assign opens_loop  = !hist_ok || beyond(since_prev, gap_limit);
  assign window_hit  = !opens_loop && beyond(since_start, window_limit);
endmodule

// File: rtl/plg_history.sv
module plg_history #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vm_entry,
  input  logic            upd,
  input  logic            opens_loop,
  input  logic [TS_W-1:0] now,
  output logic [TS_W-1:0] prev_ts,
  output logic [TS_W-1:0] start_ts,
  output logic            hist_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ts    <= '0;
      start_ts   <= '0;
      hist_valid <= 1'b0;
    end else if (upd) begin
      prev_ts    <= now;
      hist_valid <= 1'b1;
      if (opens_loop) start_ts <= now;
    end else if (vm_entry) begin
      hist_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pause_loop_gate.sv
module pause_loop_gate #(
  parameter int TS_W  = 32,
  parameter int CPL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pause_valid,
  input  logic [CPL_W-1:0] cpl,
  input  logic             ctl_pause_exit,
  input  logic             ctl_loop_exit,
  input  logic [TS_W-1:0]  gap_limit,
  input  logic [TS_W-1:0]  window_limit,
  input  logic [TS_W-1:0]  tsc_now,
  input  logic             vm_entry,
  output logic             decision_valid,
  output logic             exit_req,
  output logic [1:0]       exit_reason
);
  import plg_pkg::*;

  plg_path_e       path;
  logic [TS_W-1:0] prev_ts;
  logic [TS_W-1:0] start_ts;
  logic            hist_valid;
  logic            hist_ok;
  logic            opens_loop;
  logic            window_hit;
  logic            loop_eval;
  plg_reason_e     verdict;

  plg_route #(.CPL_W(CPL_W)) u_route (
    .cpl            (cpl),
    .ctl_pause_exit (ctl_pause_exit),
    .ctl_loop_exit  (ctl_loop_exit),
    .path           (path)
  );

  // A VM entry in the same cycle is taken as preceding the PAUSE.
  assign hist_ok   = hist_valid && !vm_entry;
  assign loop_eval = pause_valid && (path == PATH_LOOP);

  plg_judge #(.TS_W(TS_W)) u_judge (
    .now          (tsc_now),
    .prev_ts      (prev_ts),
    .start_ts     (start_ts),
    .hist_ok      (hist_ok),
    .gap_limit    (gap_limit),
    .window_limit (window_limit),
    .opens_loop   (opens_loop),
    .window_hit   (window_hit)
  );

  plg_history #(.TS_W(TS_W)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .vm_entry   (vm_entry),
    .upd        (loop_eval),
    .opens_loop (opens_loop),
    .now        (tsc_now),
    .prev_ts    (prev_ts),
    .start_ts   (start_ts),
    .hist_valid (hist_valid)
  );

  always_comb begin
    unique case (path)
      PATH_FORCED: verdict = RSN_FORCE;
      PATH_LOOP:   verdict = window_hit ? RSN_LOOP : RSN_NONE;
      default:     verdict = RSN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decision_valid <= 1'b0;
      exit_req       <= 1'b0;
      exit_reason    <= 2'b00;
    end else begin
      decision_valid <= pause_valid;
      exit_req       <= pause_valid && (verdict != RSN_NONE);
      exit_reason    <= pause_valid ? verdict : RSN_NONE;
    end
  end
endmodule

// File: rtl/plg_checker.sv
module plg_checker #(
  parameter int TS_W  = 32,
  parameter int CPL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             pause_valid,
  input logic [CPL_W-1:0] cpl,
  input logic             ctl_pause_exit,
  input logic             ctl_loop_exit,
  input logic             vm_entry,
  input logic             decision_valid,
  input logic             exit_req,
  input logic [1:0]       exit_reason,
  input logic             loop_eval,
  input logic [TS_W-1:0]  prev_ts,
  input logic [TS_W-1:0]  start_ts,
  input logic             hist_valid
);

  assert_pulse_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (decision_valid == $past(pause_valid)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !decision_valid |-> (exit_reason == 2'b00 && !exit_req));

  assert_req_matches_R9: assert property (@(posedge clk) disable iff (rst)
    decision_valid |-> (exit_req == (exit_reason != 2'b00)));

  assert_unpriv_R1: assert property (@(posedge clk) disable iff (rst)
    (pause_valid && cpl != '0) |=>
      (exit_reason == ($past(ctl_pause_exit) ? 2'b01 : 2'b00)));

  assert_forced_R2: assert property (@(posedge clk) disable iff (rst)
    (pause_valid && cpl == '0 && ctl_pause_exit) |=> (exit_reason == 2'b01));

  assert_plain_R3: assert property (@(posedge clk) disable iff (rst)
    (pause_valid && cpl == '0 && !ctl_pause_exit && !ctl_loop_exit) |=>
      (exit_reason == 2'b00));

  assert_entry_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (vm_entry && !loop_eval) |=> !hist_valid);

  assert_loop_needs_hist_R6: assert property (@(posedge clk) disable iff (rst)
    (decision_valid && exit_reason == 2'b10) |->
      ($past(hist_valid) && !$past(vm_entry) && $past(loop_eval)));

  assert_hist_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !loop_eval |=> ($stable(prev_ts) && $stable(start_ts)));
endmodule

bind pause_loop_gate plg_checker #(.TS_W(TS_W), .CPL_W(CPL_W)) u_plg_checker (
  .clk            (clk),
  .rst            (rst),
  .pause_valid    (pause_valid),
  .cpl            (cpl),
  .ctl_pause_exit (ctl_pause_exit),
  .ctl_loop_exit  (ctl_loop_exit),
  .vm_entry       (vm_entry),
  .decision_valid (decision_valid),
  .exit_req       (exit_req),
  .exit_reason    (exit_reason),
  .loop_eval      (loop_eval),
  .prev_ts        (prev_ts),
  .start_ts       (start_ts),
  .hist_valid     (hist_valid)
);

// File: tb/sim_pause_loop_gate.sv
module sim_pause_loop_gate;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pause_valid = 1'b0;
  logic [1:0]    cpl = 2'd0;
  logic          ctl_pause_exit = 1'b0;
  logic          ctl_loop_exit = 1'b0;
  logic [TW-1:0] gap_limit = '0;
  logic [TW-1:0] window_limit = '0;
  logic [TW-1:0] tsc_now = '0;
  logic          vm_entry = 1'b0;
  logic          decision_valid;
  logic          exit_req;
  logic [1:0]    exit_reason;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side history model
  logic [TW-1:0] m_prev = '0;
  logic [TW-1:0] m_start = '0;
  bit            m_hv = 1'b0;

  always #10 clk = ~clk;

  pause_loop_gate #(.TS_W(TW), .CPL_W(2)) u0 (
    .clk(clk), .rst(rst), .pause_valid(pause_valid), .cpl(cpl),
    .ctl_pause_exit(ctl_pause_exit), .ctl_loop_exit(ctl_loop_exit),
    .gap_limit(gap_limit), .window_limit(window_limit), .tsc_now(tsc_now),
    .vm_entry(vm_entry), .decision_valid(decision_valid),
    .exit_req(exit_req), .exit_reason(exit_reason)
  );

  task automatic tick();
    @(negedge clk);
    tsc_now     = tsc_now + 1'b1;
    pause_valid = 1'b0;
    vm_entry    = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic enter_vm();
    tick();
    vm_entry = 1'b1;
    m_hv = 1'b0;
    tick();
  endtask

  // Expected verdict from the requirement text.
  function automatic logic [1:0] predict(input logic [1:0] c, input bit pe,
                                         input bit pl, input bit entry_now);
    bit first;
    logic [TW-1:0] dp;
    logic [TW-1:0] ds;
    if (pe) return 2'b01;                      // R1 / R2
    if (c != 2'd0 || !pl) return 2'b00;        // R1 / R3
    dp = tsc_now - m_prev;                     // R7 modulo difference
    ds = tsc_now - m_start;
    first = !m_hv || entry_now || (dp > gap_limit);   // R4, R5
    if (first) return 2'b00;
    return (ds > window_limit) ? 2'b10 : 2'b00;       // R6
  endfunction

  task automatic model_update(input logic [1:0] c, input bit pe, input bit pl,
                              input bit entry_now);
    bit first;
    if (pe || c != 2'd0 || !pl) return;        // R8: untouched
    first = !m_hv || entry_now || ((tsc_now - m_prev) > gap_limit);
    m_prev = tsc_now;
    if (first) m_start = tsc_now;
    m_hv = 1'b1;
  endtask

  task automatic pause(input logic [1:0] c, input bit pe, input bit pl,
                       input bit with_entry, input string tag);
    logic [1:0] exp;
    tick();
    pause_valid    = 1'b1;
    cpl            = c;
    ctl_pause_exit = pe;
    ctl_loop_exit  = pl;
    vm_entry       = with_entry;
    exp = predict(c, pe, pl, with_entry);
    model_update(c, pe, pl, with_entry);
    if (with_entry && !(pe || c != 2'd0 || !pl)) m_hv = 1'b1;
    else if (with_entry) m_hv = 1'b0;
    tick();
    checks++;
    if (decision_valid !== 1'b1 || exit_reason !== exp || exit_req !== (exp != 2'b00)) begin
      fails++;
      $display("FAIL %s: valid=%0b reason=%0d req=%0b expected valid=1 reason=%0d req=%0b",
               tag, decision_valid, exit_reason, exit_req, exp, exp != 2'b00);
    end
    tick();
    checks++;
    if (decision_valid !== 1'b0 || exit_reason !== 2'b00) begin
      fails++;
      $display("FAIL R9: pulse tail valid=%0b reason=%0d expected 0/0",
               decision_valid, exit_reason);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R10: reset state
    checks++;
    if (decision_valid !== 1'b0 || exit_req !== 1'b0 || exit_reason !== 2'b00) begin
      fails++;
      $display("FAIL R10: reset outputs %0b/%0b/%0d expected 0/0/0",
               decision_valid, exit_req, exit_reason);
    end
    rst = 1'b0;
    idle(2);

    // R1 R2 R3: control priority sweep (loop controls with long gap)
    gap_limit = 8'd200; window_limit = 8'd0;
    for (int c = 0; c < 4; c++)
      for (int pe = 0; pe < 2; pe++)
        for (int pl = 0; pl < 2; pl++) begin
          enter_vm();
          pause(c[1:0], pe[0], pl[0], 1'b0, (c != 0) ? "R1" : (pe != 0) ? "R2" : "R3");
        end

    // R5: first after reset-like entry opens a loop even with tiny gap
    gap_limit = 8'd50; window_limit = 8'd1;
    enter_vm();
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R5");
    idle(4);
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R6");   // age > 1 -> loop exit
    pause(2'd0, 1'b0, 1'b1, 1'b1, "R5");   // entry same cycle: opens loop

    // R4 R6: exact boundary directed
    gap_limit = 8'd6; window_limit = 8'd12;
    enter_vm();
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R4");   // opens loop
    idle(3);                               // spacing = 6 (equal gap)
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R4");   // not first, age 6 <= 12
    idle(3);                               // age 12 (equal window)
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R6");
    idle(4);                               // spacing 7 > 6: new loop
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R4");

    // R8: foreign PAUSEs inside a loop must not move the history
    gap_limit = 8'd10; window_limit = 8'd8;
    enter_vm();
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R8");
    pause(2'd3, 1'b0, 1'b1, 1'b0, "R8");
    pause(2'd0, 1'b1, 1'b1, 1'b0, "R8");
    pause(2'd0, 1'b0, 1'b0, 1'b0, "R8");
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R8");   // age 12 > 8, spacing 12 > 10? first
    pause(2'd0, 1'b0, 1'b1, 1'b0, "R8");

    // R7: wraparound of the counter
    gap_limit = 8'd5; window_limit = 8'd6;
    tick(); tsc_now = 8'hF9;
    enter_vm();
    for (int k = 0; k < 6; k++) pause(2'd0, 1'b0, 1'b1, 1'b0, "R7");

    // near-exhaustive sweep over small thresholds and spacings
    for (int g = 0; g < 4; g++)
      for (int w = 0; w < 4; w++) begin
        gap_limit    = 8'(g * 3);
        window_limit = 8'(w * 5);
        enter_vm();
        for (int i = 0; i < 30; i++) begin
          idle((i * 7 + g * 3 + w) % 5);
          if (i % 5 == 4)      pause(2'd1, 1'b0, 1'b1, 1'b0, "R1");
          else if (i % 7 == 6) pause(2'd0, 1'b1, 1'b1, 1'b0, "R2");
          else if (i % 11 == 10) pause(2'd0, 1'b0, 1'b1, 1'b1, "R5");
          else                 pause(2'd0, 1'b0, 1'b1, 1'b0, "R6");
        end
      end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule